// File: doc/BRIEF.md
# Debug Watchpoint and Profiling Counters

This unit sits beside a processor core and watches its observation signals: the program counter of each retiring instruction, the address and value of each data access, per-cycle flags for folded instructions, load/store activity, sleep, extra instruction cycles and interrupt overhead, and interrupt entry/exit notices. Four comparators can each halt the core, or produce a sample of the program counter or of the data address, when their programmed condition is met. Comparator 0 may instead match the running cycle count. Comparator 1 may instead match the data value of an access.

A bank of profiling counters runs while the unit is enabled. There is a 32-bit cycle counter and five 8-bit event counters. Each counter gives a one-cycle pulse when it wraps. A periodic sampler produces a program-counter sample at a fixed interval of cycles. When enabled, interrupt entry and exit notices are forwarded as events. A small word-addressed register port holds the configuration and makes the counters visible. All registered outputs appear one clock after the condition that causes them.

Top module: `dwp_unit`

## Requirements
- R1: After reset, every register reads 0 and halt_req, smp_valid, ovf_evt and irq_evt_valid are low.
- R2: While the global enable (control bit 0, address 0) is 0, no counter changes except by a register write, and no comparator, sample or interrupt event output is raised.
- R3: When enabled, the cycle counter (address 1) increases by one every clock. A write to it loads the written value. When it wraps from 0xFFFFFFFF to 0, ovf_evt[0] is high for exactly the cycle that follows.
- R4: The 8-bit counters for folded, load/store, sleep, extra-cycle and interrupt-overhead activity sit at addresses 2 to 6 in that order. Each counts the clocks in which its input is high. On a wrap from 255 to 0 it pulses ovf_evt[1] to ovf_evt[5] respectively for one cycle.
- R5: Comparator i has its value at address 8+4i, its mask N (bits 3:0) at 8+4i+1, and its function at 8+4i+2. The function has action bits 1:0 (0 off, 1 halt, 2 PC sample, 3 data-address sample) and source bits 3:2 (0 PC, 1 data address, 2 cycle count, 3 data value). For an address source, the low N bits of the address and of the value are ignored in the comparison.
- R6: A match with action 1 raises halt_req in the next cycle, for one cycle per matching cycle.
- R7: A match with action 2 gives smp_valid in the next cycle with smp_data equal to the PC and smp_is_daddr=0. Action 3 gives smp_data equal to the data address and smp_is_daddr=1. When several comparators request a sample in the same cycle, the lowest-numbered one is used.
- R8: Comparator 0 with source 2 matches when the cycle counter equals its value. The cycle counter therefore reads value+1 while halt_req is high.
- R9: Comparator 1 with source 3 matches only on a valid data access whose data value equals the comparator value in all 32 bits.
- R10: Source 2 on comparators 1 to 3, and source 3 on comparators 0, 2 and 3, never match.
- R11: With control bit 1 set, a PC sample (smp_is_daddr=0, smp_data = current PC) is produced every R*(P+1) cycles. R is 64 when control bit 2 is 0 and 1024 when it is 1. P is control bits 7:4.
- R12: With control bit 8 set, an interrupt entry (or exit) notice gives irq_evt_valid in the next cycle, with irq_evt_exit 0 (or 1) and irq_evt_num taken from the notice. Entry takes precedence when both occur in one cycle. With bit 8 clear, no event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| obs_pc_valid | input | 1 | An instruction PC is presented |
| obs_pc | input | 32 | Program counter |
| obs_da_valid | input | 1 | A data access is presented |
| obs_daddr | input | 32 | Data access address |
| obs_dval | input | 32 | Data access value |
| obs_fold | input | 1 | Folded instruction this cycle |
| obs_lsu | input | 1 | Load/store unit busy this cycle |
| obs_sleep | input | 1 | Core sleeping this cycle |
| obs_cpi | input | 1 | Instruction cycle beyond the first |
| obs_exc | input | 1 | Interrupt entry/exit overhead cycle |
| obs_irq_entry | input | 1 | Interrupt entry notice |
| obs_irq_exit | input | 1 | Interrupt exit notice |
| obs_irq_num | input | 9 | Interrupt number of the notice |
| halt_req | output | 1 | Debug halt request |
| smp_valid | output | 1 | Sample strobe |
| smp_is_daddr | output | 1 | Sample is a data address (else PC) |
| smp_data | output | 32 | Sampled value |
| ovf_evt | output | 6 | Counter wrap pulses (bit 0 cycle counter) |
| irq_evt_valid | output | 1 | Interrupt event strobe |
| irq_evt_exit | output | 1 | Event is an exit (else entry) |
| irq_evt_num | output | 9 | Interrupt number of the event |

## Verification
The assertions assume that the observation inputs are free of X after reset. They also assume that the cycle counter is changed only by counting or by a register write to address 1, so its step and hold properties ignore just that one write. The stimulus drives every input from a defined value at the falling edge, keeps the valid flags low outside the cycles under test, and returns comparator functions to off after each scenario so that a leftover configuration cannot fire while a later check is in progress.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
    localparam int DATA_W   = 32;
    localparam int MASK_W   = 4;
    localparam int REG_AW   = 6;
    localparam int NSMALL   = 5;
    localparam int NEVT     = NSMALL + 1;
    localparam int PRE_W    = 10;

    localparam int REG_CTRL     = 0;
    localparam int REG_CYC      = 1;
    localparam int REG_CNT0     = 2;
    localparam int REG_CMP_BASE = 8;
    localparam int REG_CMP_STEP = 4;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'd0,
        ACT_HALT   = 2'd1,
        ACT_PC_SMP = 2'd2,
        ACT_DA_SMP = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        SRC_PC    = 2'd0,
        SRC_DADDR = 2'd1,
        SRC_CYC   = 2'd2,
        SRC_DVAL  = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        act_e act;
    } func_t;

    typedef struct packed {
        logic       irq_en;
        logic [3:0] post;
        logic       rsel;
        logic       psmp;
        logic       en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] low_mask(input logic [MASK_W-1:0] n);
        return (DATA_W'(1) << n) - DATA_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {23'd0, c.irq_en, c.post, 1'b0, c.rsel, c.psmp, c.en};
    endfunction
endpackage

// File: rtl/dwp_regs.sv
module dwp_regs
    import dwp_pkg::*;
#(
    parameter int NUM_CMP = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [REG_AW-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    output ctrl_t                            ctrl,
    output logic [NUM_CMP-1:0][DATA_W-1:0]   cmp_val,
    output logic [NUM_CMP-1:0][MASK_W-1:0]   cmp_mask,
    output func_t [NUM_CMP-1:0]              cmp_func
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && addr == REG_AW'(REG_CTRL)) begin
            ctrl <= '{irq_en: wdata[8], post: wdata[7:4], rsel: wdata[2],
                      psmp: wdata[1], en: wdata[0]};
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        localparam int BASE = REG_CMP_BASE + REG_CMP_STEP * i;
        logic [DATA_W-1:0] val_q;
        logic [MASK_W-1:0] mask_q;
        func_t             func_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q  <= '0;
                mask_q <= '0;
                func_q <= '0;
            end else if (we) begin
                if (addr == REG_AW'(BASE))     val_q  <= wdata;
                if (addr == REG_AW'(BASE + 1)) mask_q <= wdata[MASK_W-1:0];
                if (addr == REG_AW'(BASE + 2)) func_q <= func_t'(wdata[3:0]);
            end
        end

        assign cmp_val[i]  = val_q;
        assign cmp_mask[i] = mask_q;
        assign cmp_func[i] = func_q;
    end
endmodule

// File: rtl/dwp_counters.sv
module dwp_counters
    import dwp_pkg::*;
#(
    parameter int EVT_W = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           en,
    input  logic                           we,
    input  logic [REG_AW-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [NSMALL-1:0]              inc,
    output logic [DATA_W-1:0]              cyc,
    output logic [NSMALL-1:0][EVT_W-1:0]   cnt,
    output logic [NEVT-1:0]                ovf
);
    logic cyc_ovf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc     <= '0;
            cyc_ovf <= 1'b0;
        end else if (we && addr == REG_AW'(REG_CYC)) begin
            cyc     <= wdata;
            cyc_ovf <= 1'b0;
        end else if (en) begin
            cyc     <= cyc + DATA_W'(1);
            cyc_ovf <= &cyc;
        end else begin
            cyc_ovf <= 1'b0;
        end
    end

    assign ovf[0] = cyc_ovf;

    for (genvar k = 0; k < NSMALL; k++) begin : g_cnt
        logic [EVT_W-1:0] c_q;
        logic             o_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                c_q <= '0;
                o_q <= 1'b0;
            end else if (we && addr == REG_AW'(REG_CNT0 + k)) begin
                c_q <= wdata[EVT_W-1:0];
                o_q <= 1'b0;
            end else if (en && inc[k]) begin
                c_q <= c_q + EVT_W'(1);
                o_q <= &c_q;
            end else begin
                o_q <= 1'b0;
            end
        end

        assign cnt[k]   = c_q;
        assign ovf[k+1] = o_q;
    end
endmodule

// File: rtl/dwp_cmp.sv
module dwp_cmp
    import dwp_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              en,
    input  logic [DATA_W-1:0] val,
    input  logic [MASK_W-1:0] mask,
    input  func_t             func,
    input  logic              pc_valid,
    input  logic [DATA_W-1:0] pc,
    input  logic              da_valid,
    input  logic [DATA_W-1:0] daddr,
    input  logic [DATA_W-1:0] dval,
    input  logic [DATA_W-1:0] cyc,
    output logic              hit
);
    localparam bit CYC_OK  = (IDX == 0);
    localparam bit DVAL_OK = (IDX == 1);

    logic [DATA_W-1:0] care;
    logic              raw;

    always_comb begin
        care = ~low_mask(mask);
        unique case (func.src)
            SRC_PC:    raw = pc_valid && (((pc ^ val) & care) == '0);
            SRC_DADDR: raw = da_valid && (((daddr ^ val) & care) == '0);
            SRC_CYC:   raw = CYC_OK && (cyc == val);
            SRC_DVAL:  raw = DVAL_OK && da_valid && (dval == val);
            default:   raw = 1'b0;
        endcase
        hit = en && (func.act != ACT_OFF) && raw;
    end
endmodule

// File: rtl/dwp_sampler.sv
module dwp_sampler
    import dwp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int IRQ_W   = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic [NUM_CMP-1:0] hit,
    input  act_e [NUM_CMP-1:0] act,
    input  logic [DATA_W-1:0]  pc,
    input  logic [DATA_W-1:0]  daddr,
    input  logic               irq_entry,
    input  logic               irq_exit,
    input  logic [IRQ_W-1:0]   irq_num,
    output logic               halt_req,
    output logic               smp_valid,
    output logic               smp_is_daddr,
    output logic [DATA_W-1:0]  smp_data,
    output logic               irq_evt_valid,
    output logic               irq_evt_exit,
    output logic [IRQ_W-1:0]   irq_evt_num
);
    logic             any_halt;
    logic             sel_hit;
    logic             sel_da;
    logic [PRE_W-1:0] pre_q;
    logic [3:0]       post_q;
    logic [PRE_W-1:0] pre_last;
    logic             run;
    logic             per_fire;

    always_comb begin
        any_halt = 1'b0;
        sel_hit  = 1'b0;
        sel_da   = 1'b0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hit[i] && act[i] == ACT_HALT) any_halt = 1'b1;
            if (hit[i] && (act[i] == ACT_PC_SMP || act[i] == ACT_DA_SMP)) begin
                sel_hit = 1'b1;
                sel_da  = (act[i] == ACT_DA_SMP);
            end
        end
    end

    assign run      = ctrl.en && ctrl.psmp;
    assign pre_last = ctrl.rsel ? PRE_W'(1023) : PRE_W'(63);
    assign per_fire = run && (pre_q == pre_last) && (post_q == ctrl.post);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (pre_q >= pre_last) begin
            pre_q  <= '0;
            post_q <= (post_q == ctrl.post) ? 4'd0 : post_q + 4'd1;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_req      <= 1'b0;
            smp_valid     <= 1'b0;
            smp_is_daddr  <= 1'b0;
            smp_data      <= '0;
            irq_evt_valid <= 1'b0;
            irq_evt_exit  <= 1'b0;
            irq_evt_num   <= '0;
        end else begin
            halt_req  <= any_halt;
            smp_valid <= sel_hit || per_fire;
            if (sel_hit) begin
                smp_is_daddr <= sel_da;
                smp_data     <= sel_da ? daddr : pc;
            end else if (per_fire) begin
                smp_is_daddr <= 1'b0;
                smp_data     <= pc;
            end
            irq_evt_valid <= ctrl.en && ctrl.irq_en && (irq_entry || irq_exit);
            irq_evt_exit  <= !irq_entry;
            irq_evt_num   <= irq_num;
        end
    end
endmodule

// File: rtl/dwp_unit.sv
module dwp_unit
    import dwp_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int EVT_W   = 8,
    parameter int IRQ_W   = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [REG_AW-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic                obs_pc_valid,
    input  logic [DATA_W-1:0]   obs_pc,
    input  logic                obs_da_valid,
    input  logic [DATA_W-1:0]   obs_daddr,
    input  logic [DATA_W-1:0]   obs_dval,
    input  logic                obs_fold,
    input  logic                obs_lsu,
    input  logic                obs_sleep,
    input  logic                obs_cpi,
    input  logic                obs_exc,
    input  logic                obs_irq_entry,
    input  logic                obs_irq_exit,
    input  logic [IRQ_W-1:0]    obs_irq_num,
    output logic                halt_req,
    output logic                smp_valid,
    output logic                smp_is_daddr,
    output logic [DATA_W-1:0]   smp_data,
    output logic [NEVT-1:0]     ovf_evt,
    output logic                irq_evt_valid,
    output logic                irq_evt_exit,
    output logic [IRQ_W-1:0]    irq_evt_num
);
    ctrl_t                           ctrl;
    logic [NUM_CMP-1:0][DATA_W-1:0]  cmp_val;
    logic [NUM_CMP-1:0][MASK_W-1:0]  cmp_mask;
    func_t [NUM_CMP-1:0]             cmp_func;
    act_e  [NUM_CMP-1:0]             cmp_act;
    logic [NUM_CMP-1:0]              cmp_hit;
    logic [DATA_W-1:0]               cyc_cnt;
    logic [NSMALL-1:0][EVT_W-1:0]    small_cnt;
    logic                            glb_en;

    assign glb_en = ctrl.en;

    dwp_regs #(.NUM_CMP(NUM_CMP)) u_regs (
        .clk, .rst, .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl, .cmp_val, .cmp_mask, .cmp_func
    );

    dwp_counters #(.EVT_W(EVT_W)) u_cnt (
        .clk, .rst, .en(glb_en), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .inc({obs_exc, obs_cpi, obs_sleep, obs_lsu, obs_fold}),
        .cyc(cyc_cnt), .cnt(small_cnt), .ovf(ovf_evt)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        dwp_cmp #(.IDX(i)) u_cmp (
            .en(glb_en), .val(cmp_val[i]), .mask(cmp_mask[i]), .func(cmp_func[i]),
            .pc_valid(obs_pc_valid), .pc(obs_pc), .da_valid(obs_da_valid),
            .daddr(obs_daddr), .dval(obs_dval), .cyc(cyc_cnt), .hit(cmp_hit[i])
        );
        assign cmp_act[i] = cmp_func[i].act;
    end

    dwp_sampler #(.NUM_CMP(NUM_CMP), .IRQ_W(IRQ_W)) u_smp (
        .clk, .rst, .ctrl, .hit(cmp_hit), .act(cmp_act), .pc(obs_pc), .daddr(obs_daddr),
        .irq_entry(obs_irq_entry), .irq_exit(obs_irq_exit), .irq_num(obs_irq_num),
        .halt_req, .smp_valid, .smp_is_daddr, .smp_data,
        .irq_evt_valid, .irq_evt_exit, .irq_evt_num
    );

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == REG_AW'(REG_CTRL)) cfg_rdata = ctrl_to_word(ctrl);
        if (cfg_addr == REG_AW'(REG_CYC))  cfg_rdata = cyc_cnt;
        for (int k = 0; k < NSMALL; k++) begin
            if (cfg_addr == REG_AW'(REG_CNT0 + k)) cfg_rdata = DATA_W'(small_cnt[k]);
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (cfg_addr == REG_AW'(REG_CMP_BASE + REG_CMP_STEP * i))
                cfg_rdata = cmp_val[i];
            if (cfg_addr == REG_AW'(REG_CMP_BASE + REG_CMP_STEP * i + 1))
                cfg_rdata = DATA_W'(cmp_mask[i]);
            if (cfg_addr == REG_AW'(REG_CMP_BASE + REG_CMP_STEP * i + 2))
                cfg_rdata = DATA_W'(cmp_func[i]);
        end
    end
endmodule

// File: rtl/dwp_unit_chk.sv
module dwp_unit_chk
    import dwp_pkg::*;
#(
    parameter int IRQ_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              glb_en,
    input logic              cfg_we,
    input logic [REG_AW-1:0] cfg_addr,
    input logic [DATA_W-1:0] cyc_cnt,
    input logic              halt_req,
    input logic              smp_valid,
    input logic [NEVT-1:0]   ovf_evt,
    input logic              irq_evt_valid,
    input logic              obs_irq_entry,
    input logic              obs_irq_exit,
    input logic [IRQ_W-1:0]  obs_irq_num,
    input logic [IRQ_W-1:0]  irq_evt_num
);
    logic cyc_wr;
    assign cyc_wr = cfg_we && (cfg_addr == REG_AW'(REG_CYC));

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> (!halt_req && !smp_valid && ovf_evt == '0 && !irq_evt_valid)); // R2

    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (glb_en && !cyc_wr) |=> (cyc_cnt == $past(cyc_cnt) + DATA_W'(1))); // R3

    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!glb_en && !cyc_wr) |=> $stable(cyc_cnt)); // R2

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (|ovf_evt) |=> ((ovf_evt & $past(ovf_evt)) == '0)); // R4

    AST_CYC_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_evt[0]) |-> (cyc_cnt == '0)); // R3

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_evt_valid |-> ($past(obs_irq_entry || obs_irq_exit)
                           && irq_evt_num == $past(obs_irq_num))); // R12
endmodule

bind dwp_unit dwp_unit_chk #(.IRQ_W(IRQ_W)) u_chk (
    .clk, .rst, .glb_en, .cfg_we, .cfg_addr, .cyc_cnt, .halt_req, .smp_valid,
    .ovf_evt, .irq_evt_valid, .obs_irq_entry, .obs_irq_exit, .obs_irq_num, .irq_evt_num
);

// File: tb/dwp_unit_test.sv
module dwp_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        obs_pc_valid = 1'b0;
    logic [31:0] obs_pc = '0;
    logic        obs_da_valid = 1'b0;
    logic [31:0] obs_daddr = '0;
    logic [31:0] obs_dval = '0;
    logic [4:0]  ev = '0;
    logic        obs_irq_entry = 1'b0;
    logic        obs_irq_exit = 1'b0;
    logic [8:0]  obs_irq_num = '0;
    logic        halt_req, smp_valid, smp_is_daddr;
    logic [31:0] smp_data;
    logic [5:0]  ovf_evt;
    logic        irq_evt_valid, irq_evt_exit;
    logic [8:0]  irq_evt_num;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dwp_unit uut (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .obs_pc_valid, .obs_pc, .obs_da_valid, .obs_daddr, .obs_dval,
        .obs_fold(ev[0]), .obs_lsu(ev[1]), .obs_sleep(ev[2]), .obs_cpi(ev[3]), .obs_exc(ev[4]),
        .obs_irq_entry, .obs_irq_exit, .obs_irq_num,
        .halt_req, .smp_valid, .smp_is_daddr, .smp_data, .ovf_evt,
        .irq_evt_valid, .irq_evt_exit, .irq_evt_num
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 halt", {31'd0, halt_req}, 0);
        chk("R1 smp", {31'd0, smp_valid}, 0);
        chk("R1 ovf", {26'd0, ovf_evt}, 0);
        chk("R1 irq", {31'd0, irq_evt_valid}, 0);
        for (int a = 0; a < 24; a++) begin
            rd(6'(a), d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_gate();
        logic [31:0] a, b;
        wr(16, 32'h40); wr(18, 32'h1);
        obs_pc_valid = 1'b1; obs_pc = 32'h40; ev = 5'b11111;
        rd(1, a);
        idle(5);
        rd(1, b);
        chk("R2 cyc hold", b, a);
        chk("R2 halt off", {31'd0, halt_req}, 0);
        rd(2, b);
        chk("R2 fold hold", b, 0);
        obs_pc_valid = 1'b0; ev = '0;
        wr(18, 0);
    endtask

    task automatic t_cyc();
        logic [31:0] a, b;
        rd(1, a);
        idle(10);
        rd(1, b);
        chk("R3 step", b - a, 10);
        wr(1, 32'hFFFF_FFFD);
        rd(1, b);
        chk("R3 load", b, 32'hFFFF_FFFD);
        idle(2);
        chk("R3 no early wrap", {26'd0, ovf_evt}, 0);
        idle(1);
        chk("R3 wrap pulse", {26'd0, ovf_evt}, 1);
        rd(1, b);
        chk("R3 wrapped", b, 0);
        idle(1);
        chk("R3 pulse one cycle", {26'd0, ovf_evt}, 0);
    endtask

    task automatic t_small();
        logic [31:0] d;
        for (int k = 0; k < 5; k++) begin
            wr(6'(2 + k), 253);
            ev[k] = 1'b1;
            idle(2);
            chk("R4 before wrap", {26'd0, ovf_evt}, 0);
            idle(1);
            ev[k] = 1'b0;
            chk("R4 wrap bit", {26'd0, ovf_evt}, 32'(1) << (k + 1));
            rd(6'(2 + k), d);
            chk("R4 wrapped", d, 0);
            idle(1);
            chk("R4 pulse one cycle", {26'd0, ovf_evt}, 0);
        end
        ev[0] = 1'b1;
        idle(3);
        ev[0] = 1'b0;
        rd(2, d);
        chk("R4 counts", d, 3);
        rd(3, d);
        chk("R4 other unchanged", d, 0);
    endtask

    task automatic t_mask();
        wr(16, 32'h1000); wr(17, 4); wr(18, 1);
        obs_pc_valid = 1'b1; obs_pc = 32'h100F;
        idle(1);
        chk("R6 halt in range", {31'd0, halt_req}, 1);
        obs_pc = 32'h1010;
        idle(1);
        chk("R5 outside range", {31'd0, halt_req}, 0);
        obs_pc = 32'h1000;
        idle(1);
        chk("R5 base in range", {31'd0, halt_req}, 1);
        obs_pc_valid = 1'b0;
        idle(1);
        chk("R6 one cycle", {31'd0, halt_req}, 0);
        wr(17, 0);
        obs_pc_valid = 1'b1; obs_pc = 32'h1001;
        idle(1);
        chk("R5 no mask exact", {31'd0, halt_req}, 0);
        obs_pc_valid = 1'b0;
        wr(18, 0);
    endtask

    task automatic t_sample();
        wr(16, 32'h3000); wr(17, 0); wr(18, 2);
        wr(20, 32'h2000); wr(21, 0); wr(22, 7);
        obs_da_valid = 1'b1; obs_daddr = 32'h2000; obs_pc = 32'h7777;
        idle(1);
        chk("R7 da valid", {31'd0, smp_valid}, 1);
        chk("R7 da kind", {31'd0, smp_is_daddr}, 1);
        chk("R7 da data", smp_data, 32'h2000);
        obs_pc_valid = 1'b1; obs_pc = 32'h3000;
        idle(1);
        chk("R7 priority data", smp_data, 32'h3000);
        chk("R7 priority kind", {31'd0, smp_is_daddr}, 0);
        chk("R7 no halt", {31'd0, halt_req}, 0);
        obs_pc_valid = 1'b0; obs_da_valid = 1'b0;
        idle(1);
        chk("R7 strobe ends", {31'd0, smp_valid}, 0);
        wr(18, 0); wr(22, 0);
    endtask

    task automatic t_cyccmp();
        logic [31:0] d;
        int n = 0;
        wr(8, 32'h500); wr(10, 9); wr(1, 32'h400);
        cfg_addr = 1;
        while (!halt_req && n < 2000) begin
            @(negedge clk);
            n++;
        end
        rd(1, d);
        chk("R8 seen", {31'd0, halt_req}, 1);
        chk("R8 count at halt", d, 32'h501);
        wr(10, 0);
    endtask

    task automatic t_dval();
        wr(12, 32'hDEAD_BEEF); wr(14, 13);
        obs_da_valid = 1'b1; obs_daddr = 32'h0; obs_dval = 32'hDEAD_BEEF;
        idle(1);
        chk("R9 value match", {31'd0, halt_req}, 1);
        obs_dval = 32'hDEAD_BEEE;
        idle(1);
        chk("R9 value differs", {31'd0, halt_req}, 0);
        obs_da_valid = 1'b0; obs_dval = 32'hDEAD_BEEF;
        idle(1);
        chk("R9 needs valid", {31'd0, halt_req}, 0);
        wr(14, 0);
    endtask

    task automatic t_illegal();
        int hits = 0;
        wr(20, 32'h55); wr(22, 13);
        obs_da_valid = 1'b1; obs_dval = 32'h55;
        idle(1);
        chk("R10 value on cmp3", {31'd0, halt_req}, 0);
        obs_da_valid = 1'b0;
        wr(22, 0);
        wr(16, 32'h800); wr(18, 9); wr(1, 32'h7F0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (halt_req) hits++;
        end
        chk("R10 cycle on cmp2", 32'(hits), 0);
        wr(18, 0);
    endtask

    task automatic measure(input string req, input int period);
        int n = 0;
        while (!smp_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " kind"}, {31'd0, smp_is_daddr}, 0);
        chk({req, " data"}, smp_data, 32'hABC0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!smp_valid && n < 20000);
        chk({req, " period"}, 32'(n), 32'(period));
    endtask

    task automatic t_periodic();
        obs_pc = 32'hABC0;
        wr(0, 32'h13);
        measure("R11 64x2", 128);
        wr(0, 32'h07);
        measure("R11 1024x1", 1024);
        wr(0, 32'h01);
    endtask

    task automatic t_irq();
        wr(0, 32'h101);
        obs_irq_entry = 1'b1; obs_irq_num = 9'd5;
        idle(1);
        chk("R12 entry valid", {31'd0, irq_evt_valid}, 1);
        chk("R12 entry kind", {31'd0, irq_evt_exit}, 0);
        chk("R12 entry num", {23'd0, irq_evt_num}, 5);
        obs_irq_entry = 1'b0; obs_irq_exit = 1'b1; obs_irq_num = 9'd7;
        idle(1);
        chk("R12 exit kind", {31'd0, irq_evt_exit}, 1);
        chk("R12 exit num", {23'd0, irq_evt_num}, 7);
        obs_irq_exit = 1'b0;
        idle(1);
        chk("R12 idle", {31'd0, irq_evt_valid}, 0);
        wr(0, 32'h1);
        obs_irq_entry = 1'b1;
        idle(1);
        chk("R12 disabled", {31'd0, irq_evt_valid}, 0);
        obs_irq_entry = 1'b0;
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_gate();
        wr(0, 32'h1);
        t_cyc();
        t_small();
        t_mask();
        t_sample();
        t_cyccmp();
        t_dval();
        t_illegal();
        t_periodic();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule